// File: doc/BRIEF.md
# Banked Host Control Register Block

This block is the host-side control register file for an eight-channel line interface. A synchronous bus with a 5-bit address and 8-bit data reaches four register banks. Only one bank is visible at a time. A bank pointer sits at the top address, 0x1F, and is present in every bank, so software can always move to another bank. The pointer uses sparse code values. A pointer value outside the defined set hides every bank, which keeps stray writes away from live control fields.

The per-channel bank holds the controls that the line logic uses: a channel enable byte, a clock select byte, a latched line-violation status byte with its interrupt enable byte, and a control register whose bit 0 sets how status is cleared. Outside logic sends violation events as one-cycle pulses. Each pulse latches a status bit. Software clears the status either by reading it or by writing ones to it, and the control bit chooses which. The tester bank shows two 32-bit event counters as read-only bytes. The primary and secondary banks are plain read/write storage for the wider chip.

A single active-low interrupt output reports whether any enabled status bit is latched. Reads return data in the cycle after the request, from a registered data output.

Top module: `lif_host_regs`

## Requirements
- R1: During and after reset, the bank pointer is 0x00, chan_en_o, clk_sel_o, the status and interrupt-enable bytes are zero, the clear mode is clear-on-read (control bit 0 = 0), irq_n is 1 and rdata is 0x00.
- R2: Address 0x1F reads and writes the 8-bit bank pointer in every bank. Pointer code 0x00 selects the primary bank, 0xAA the secondary bank, 0x01 the per-channel bank and 0x02 the tester bank.
- R3: While the pointer holds any other value, addresses 0x00–0x1E read 0x00 and writes to them change nothing.
- R4: The primary bank stores bytes at 0x00–0x15 and the secondary bank stores bytes at 0x00–0x06. The two banks are separate. Their other addresses below 0x1F read 0x00 and ignore writes.
- R5: In the per-channel bank, 0x00 is the channel enable byte (bit i = channel i) driven on chan_en_o, 0x06 is the clock select byte driven on clk_sel_o, and 0x11 is the interrupt enable byte. In 0x1E, bit 0 is the clear mode and the other bits read 0. All other addresses below 0x1F are reserved: they read 0x00 and ignore writes.
- R6: Per-channel address 0x12 is the status byte. A pulse on lv_evt[i] sets bit i, and the bit stays set until it is cleared. In clear-on-read mode, writes to 0x12 have no effect.
- R7: In clear-on-read mode, a read of 0x12 returns the current status and then clears every bit.
- R8: In clear-on-write mode (bit 0 of 0x1E = 1), writing 1 to a status bit clears it and writing 0 leaves it unchanged. Reads do not clear.
- R9: An event and a clear of the same bit in the same cycle leave the bit set.
- R10: irq_n is low exactly when some status bit and its enable bit are both 1. It updates at the same clock edge as the status and enable bytes.
- R11: The tester bank holds a 32-bit count of err_tick pulses at 0x14–0x17 and a 32-bit count of bit_tick pulses at 0x18–0x1B, least significant byte at the lowest address. The counts are read-only and wrap. Other tester addresses below 0x1F read 0x00.
- R12: A read captured at a clock edge puts its data on rdata at that edge, and rdata holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read request for addr |
| wr_en | input | 1 | Write request of wdata to addr |
| addr | input | 5 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| lv_evt | input | 8 | Per-channel violation event pulses |
| err_tick | input | 1 | Increments the error counter |
| bit_tick | input | 1 | Increments the bit counter |
| chan_en_o | output | 8 | Per-channel enable bits |
| clk_sel_o | output | 8 | Clock select byte |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assertions check on every cycle that irq_n agrees with the latched status and enable bytes, that an event is never lost to a clear in the same cycle, that a full clear leaves only the new events, that the counters step by exactly one, that rdata holds between reads, and that writes under an unrecognised pointer leave the control state alone. Only the bench scenarios can show the bank code mapping, the isolation between banks, reserved addresses reading zero, the two clear modes set by software, and the byte order of the counters. The bench does this against a behavioural model that it compares on every clock.

// File: rtl/lif_regs_pkg.sv
package lif_regs_pkg;
  typedef enum logic [1:0] {BK_PRI, BK_SEC, BK_CHN, BK_TST} bank_e;

  localparam logic [7:0] CODE_PRI = 8'h00;
  localparam logic [7:0] CODE_SEC = 8'hAA;
  localparam logic [7:0] CODE_CHN = 8'h01;
  localparam logic [7:0] CODE_TST = 8'h02;

  localparam logic [4:0] A_PTR     = 5'h1F;
  localparam logic [4:0] A_CH_EN   = 5'h00;
  localparam logic [4:0] A_CH_CLK  = 5'h06;
  localparam logic [4:0] A_CH_IEN  = 5'h11;
  localparam logic [4:0] A_CH_STS  = 5'h12;
  localparam logic [4:0] A_CH_CTL  = 5'h1E;
  localparam logic [4:0] A_TST_ERR = 5'h14;
  localparam logic [4:0] A_TST_BIT = 5'h18;
endpackage

// File: rtl/lif_bank_decode.sv
module lif_bank_decode
  import lif_regs_pkg::*;
(
  input  logic [7:0] ptr,
  output bank_e      bank,
  output logic       valid
);
  always_comb begin
    valid = 1'b1;
    bank  = BK_PRI;
    case (ptr)
      CODE_PRI: bank = BK_PRI;
      CODE_SEC: bank = BK_SEC;
      CODE_CHN: bank = BK_CHN;
      CODE_TST: bank = BK_TST;
      default:  valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/lif_event_counter.sv
module lif_event_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  output logic [W-1:0] count_o
);
  always_ff @(posedge clk) begin
    if (rst)       count_o <= '0;
    else if (tick) count_o <= count_o + W'(1);
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    tick |=> (count_o == $past(count_o) + W'(1))); // R11
  AST_COUNT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(count_o)); // R11
endmodule

// File: rtl/lif_status_latch.sv
module lif_status_latch #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] clr_mask,
  input  logic         ien_we,
  input  logic [N-1:0] ien_wdata,
  output logic [N-1:0] status_o,
  output logic [N-1:0] ien_o,
  output logic         irq_n_o
);
  logic [N-1:0] st_d, ien_d;

  always_comb begin
    st_d  = evt | (status_o & ~clr_mask);
    ien_d = ien_we ? ien_wdata : ien_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_o <= '0;
      ien_o    <= '0;
      irq_n_o  <= 1'b1;
    end else begin
      status_o <= st_d;
      ien_o    <= ien_d;
      irq_n_o  <= ~|(st_d & ien_d);
    end
  end

  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst)
    irq_n_o == !(|(status_o & ien_o))); // R10
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> ((status_o & $past(evt)) == $past(evt))); // R9
  AST_FULL_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (&clr_mask) |=> (status_o == $past(evt))); // R7
endmodule

// File: rtl/lif_host_regs.sv
module lif_host_regs
  import lif_regs_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int DW    = 8,
  parameter int AW    = 5,
  parameter int CNT_W = 32,
  parameter int PRI_N = 22,
  parameter int SEC_N = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [NCH-1:0] lv_evt,
  input  logic          err_tick,
  input  logic          bit_tick,
  output logic [NCH-1:0] chan_en_o,
  output logic [DW-1:0] clk_sel_o,
  output logic          irq_n
);
  localparam int PRI_AW    = $clog2(PRI_N);
  localparam int SEC_AW    = $clog2(SEC_N);
  localparam int CNT_BYTES = CNT_W / DW;

  logic [7:0]    ptr_q;
  logic [DW-1:0] pri_mem [PRI_N];
  logic [DW-1:0] sec_mem [SEC_N];
  logic          cow_q;
  bank_e         bank;
  logic          bank_ok;
  logic          wr_reg, sts_rd, sts_wr;
  logic [NCH-1:0] clr_mask, status, ien;
  logic [DW-1:0] rd_mux;
  logic [1:0]    ticks;
  logic [CNT_W-1:0] cnt [2];

  lif_bank_decode u_dec (.ptr(ptr_q), .bank(bank), .valid(bank_ok));

  assign wr_reg = wr_en && bank_ok && (addr != A_PTR);
  assign sts_rd = rd_en && bank_ok && (bank == BK_CHN) && (addr == A_CH_STS);
  assign sts_wr = wr_reg && (bank == BK_CHN) && (addr == A_CH_STS);

  always_comb begin
    if (sts_rd && !cow_q)      clr_mask = '1;
    else if (sts_wr && cow_q)  clr_mask = wdata[NCH-1:0];
    else                       clr_mask = '0;
  end

  lif_status_latch #(.N(NCH)) u_sts (
    .clk(clk), .rst(rst), .evt(lv_evt), .clr_mask(clr_mask),
    .ien_we(wr_reg && (bank == BK_CHN) && (addr == A_CH_IEN)),
    .ien_wdata(wdata[NCH-1:0]),
    .status_o(status), .ien_o(ien), .irq_n_o(irq_n)
  );

  assign ticks = {bit_tick, err_tick};
  for (genvar g = 0; g < 2; g++) begin : g_cnt
    lif_event_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .tick(ticks[g]), .count_o(cnt[g])
    );
  end

  // storage banks: no reset so the arrays can map to RAM
  always_ff @(posedge clk) begin
    if (wr_reg && bank == BK_PRI && int'(addr) < PRI_N)
      pri_mem[addr[PRI_AW-1:0]] <= wdata;
    if (wr_reg && bank == BK_SEC && int'(addr) < SEC_N)
      sec_mem[addr[SEC_AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q     <= CODE_PRI;
      chan_en_o <= '0;
      clk_sel_o <= '0;
      cow_q     <= 1'b0;
    end else begin
      if (wr_en && addr == A_PTR) ptr_q <= wdata[7:0];
      if (wr_reg && bank == BK_CHN) begin
        case (addr)
          A_CH_EN:  chan_en_o <= wdata[NCH-1:0];
          A_CH_CLK: clk_sel_o <= wdata;
          A_CH_CTL: cow_q     <= wdata[0];
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr == A_PTR) begin
      rd_mux = DW'(ptr_q);
    end else if (bank_ok) begin
      case (bank)
        BK_PRI: if (int'(addr) < PRI_N) rd_mux = pri_mem[addr[PRI_AW-1:0]];
        BK_SEC: if (int'(addr) < SEC_N) rd_mux = sec_mem[addr[SEC_AW-1:0]];
        BK_CHN: begin
          case (addr)
            A_CH_EN:  rd_mux = DW'(chan_en_o);
            A_CH_CLK: rd_mux = clk_sel_o;
            A_CH_IEN: rd_mux = DW'(ien);
            A_CH_STS: rd_mux = DW'(status);
            A_CH_CTL: rd_mux = DW'(cow_q);
            default:  rd_mux = '0;
          endcase
        end
        default: begin
          if (addr >= A_TST_ERR && int'(addr) < int'(A_TST_ERR) + CNT_BYTES)
            rd_mux = DW'(cnt[0] >> (DW * int'(addr - A_TST_ERR)));
          else if (addr >= A_TST_BIT && int'(addr) < int'(A_TST_BIT) + CNT_BYTES)
            rd_mux = DW'(cnt[1] >> (DW * int'(addr - A_TST_BIT)));
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  AST_PTR_RESET: assert property (@(posedge clk)
    rst |=> (ptr_q == CODE_PRI)); // R1
  AST_BAD_PTR_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !bank_ok && addr != A_PTR) |=>
      ($stable(chan_en_o) && $stable(clk_sel_o) && $stable(cow_q))); // R3
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata)); // R12
endmodule

// File: tb/tb_lif_host_regs.sv
module tb_lif_host_regs;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic rd_en = 0, wr_en = 0, err_tick = 0, bit_tick = 0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0, lv_evt = '0;
  logic [7:0] rdata, chan_en_o, clk_sel_o;
  logic irq_n;
  int total = 0, bad = 0;
  bit started = 0, done = 0;

  always #(CLK_NS/2) clk = ~clk;

  lif_host_regs dut (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .lv_evt(lv_evt), .err_tick(err_tick),
    .bit_tick(bit_tick), .chan_en_o(chan_en_o), .clk_sel_o(clk_sel_o),
    .irq_n(irq_n)
  );

  // behavioural reference model
  logic [7:0] m_ptr, m_en, m_cs, m_ien, m_st, m_rd;
  logic [7:0] m_pri [22];
  logic [7:0] m_sec [7];
  logic [31:0] m_err, m_bit;
  bit m_cow, m_irq;

  function automatic bit m_ok();
    return m_ptr == 8'h00 || m_ptr == 8'hAA || m_ptr == 8'h01 || m_ptr == 8'h02;
  endfunction

  function automatic logic [7:0] m_read(input int a);
    if (a == 31) return m_ptr;
    if (!m_ok()) return 8'h00;
    if (m_ptr == 8'h00) return (a < 22) ? m_pri[a] : 8'h00;
    if (m_ptr == 8'hAA) return (a < 7) ? m_sec[a] : 8'h00;
    if (m_ptr == 8'h01) begin
      if (a == 0) return m_en;
      if (a == 6) return m_cs;
      if (a == 17) return m_ien;
      if (a == 18) return m_st;
      if (a == 30) return {7'd0, m_cow};
      return 8'h00;
    end
    if (a >= 20 && a < 24) return 8'((m_err >> (8 * (a - 20))));
    if (a >= 24 && a < 28) return 8'((m_bit >> (8 * (a - 24))));
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    logic [7:0] clr;
    if (rst) begin
      m_ptr = 0; m_en = 0; m_cs = 0; m_ien = 0; m_st = 0; m_rd = 0;
      m_err = 0; m_bit = 0; m_cow = 0; m_irq = 0;
    end else begin
      clr = 8'h00;
      if (rd_en) begin
        m_rd = m_read(int'(addr));
        if (m_ptr == 8'h01 && addr == 5'h12 && !m_cow) clr = 8'hFF;
      end
      if (wr_en) begin
        if (addr == 5'h1F) m_ptr = wdata;
        else if (m_ok()) begin
          if (m_ptr == 8'h00 && addr < 22) m_pri[addr] = wdata;
          else if (m_ptr == 8'hAA && addr < 7) m_sec[addr] = wdata;
          else if (m_ptr == 8'h01) begin
            if (addr == 0) m_en = wdata;
            else if (addr == 6) m_cs = wdata;
            else if (addr == 17) m_ien = wdata;
            else if (addr == 18 && m_cow) clr = wdata;
            else if (addr == 30) m_cow = wdata[0];
          end
        end
      end
      m_st = lv_evt | (m_st & ~clr);
      if (err_tick) m_err++;
      if (bit_tick) m_bit++;
      m_irq = |(m_st & m_ien);
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (started && !done) begin
    chk(irq_n === !m_irq, "R10 irq_n vs model", irq_n, !m_irq);
    chk(chan_en_o === m_en, "R5 chan_en_o vs model", chan_en_o, m_en);
    chk(clk_sel_o === m_cs, "R5 clk_sel_o vs model", clk_sel_o, m_cs);
    chk(rdata === m_rd, "R12 rdata vs model", rdata, m_rd);
  end

  task automatic wr(input logic [4:0] a, input logic [7:0] d, input logic [7:0] ev = 0);
    @(negedge clk); wr_en = 1; addr = a; wdata = d; lv_evt = ev;
    @(negedge clk); wr_en = 0; lv_evt = 0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [7:0] exp, input string tag, input logic [7:0] ev = 0);
    @(negedge clk); rd_en = 1; addr = a; lv_evt = ev;
    @(negedge clk); rd_en = 0; lv_evt = 0;
    chk(rdata === exp, tag, rdata, exp);
  endtask

  task automatic pulse(input logic [7:0] v);
    @(negedge clk); lv_evt = v;
    @(negedge clk); lv_evt = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0; started = 1;
    chk(irq_n === 1'b1 && chan_en_o === 8'h00 && rdata === 8'h00, "R1 reset outputs", {irq_n, chan_en_o, rdata}, 32'h10000);
    rd(5'h1F, 8'h00, "R1 pointer reset");
    // primary bank
    wr(5'h05, 8'h3C); wr(5'h15, 8'h81); wr(5'h16, 8'hFF);
    rd(5'h05, 8'h3C, "R4 primary 0x05");
    rd(5'h15, 8'h81, "R4 primary 0x15");
    rd(5'h16, 8'h00, "R4 primary reserved 0x16");
    // secondary bank
    wr(5'h1F, 8'hAA); rd(5'h1F, 8'hAA, "R2 pointer readback");
    wr(5'h06, 8'h5A); wr(5'h07, 8'h11);
    rd(5'h06, 8'h5A, "R4 secondary 0x06");
    rd(5'h07, 8'h00, "R4 secondary reserved 0x07");
    wr(5'h1F, 8'h00); rd(5'h05, 8'h3C, "R2 primary kept apart from secondary");
    // unknown pointer
    wr(5'h1F, 8'h55); rd(5'h05, 8'h00, "R3 hidden read");
    wr(5'h05, 8'hEE); wr(5'h1F, 8'h00);
    rd(5'h05, 8'h3C, "R3 hidden write ignored");
    // per-channel bank
    wr(5'h1F, 8'h01);
    wr(5'h00, 8'hA5); chk(chan_en_o === 8'hA5, "R5 chan_en_o", chan_en_o, 8'hA5);
    wr(5'h06, 8'h07); chk(clk_sel_o === 8'h07, "R5 clk_sel_o", clk_sel_o, 8'h07);
    wr(5'h03, 8'hFF); rd(5'h03, 8'h00, "R5 reserved per-channel");
    rd(5'h1E, 8'h00, "R1 clear-on-read default");
    pulse(8'h09); rd(5'h12, 8'h09, "R6 latched events");
    rd(5'h12, 8'h00, "R7 cleared by read");
    pulse(8'h04); wr(5'h12, 8'hFF); rd(5'h12, 8'h04, "R6 write ignored in read mode");
    rd(5'h12, 8'h00, "R7 cleared by read again");
    wr(5'h11, 8'h02);
    pulse(8'h01); chk(irq_n === 1'b1, "R10 masked event", irq_n, 1);
    rd(5'h12, 8'h01, "R7 masked event read");
    pulse(8'h02); chk(irq_n === 1'b0, "R10 enabled event", irq_n, 0);
    rd(5'h12, 8'h02, "R7 enabled event read");
    chk(irq_n === 1'b1, "R10 release after clear", irq_n, 1);
    rd(5'h12, 8'h00, "R9 read with event", 8'h02);
    chk(irq_n === 1'b0, "R9 event kept over clear", irq_n, 0);
    rd(5'h12, 8'h02, "R9 status kept");
    // clear-on-write
    wr(5'h1E, 8'hFF); rd(5'h1E, 8'h01, "R5 control upper bits zero");
    pulse(8'h30); rd(5'h12, 8'h30, "R8 status set");
    rd(5'h12, 8'h30, "R8 read does not clear");
    wr(5'h12, 8'h10); rd(5'h12, 8'h20, "R8 write one clears");
    wr(5'h12, 8'h20); rd(5'h12, 8'h00, "R8 second clear");
    wr(5'h12, 8'h40, 8'h40); rd(5'h12, 8'h40, "R9 set beats write clear");
    wr(5'h12, 8'h40);
    // tester bank
    wr(5'h1F, 8'h02);
    @(negedge clk); err_tick = 1; bit_tick = 1;
    repeat (3) @(negedge clk);
    err_tick = 0;
    repeat (302) @(negedge clk);
    bit_tick = 0;
    rd(5'h14, 8'h03, "R11 error count byte 0");
    rd(5'h15, 8'h00, "R11 error count byte 1");
    rd(5'h18, 8'h31, "R11 bit count byte 0");
    rd(5'h19, 8'h01, "R11 bit count byte 1");
    wr(5'h14, 8'hFF); rd(5'h14, 8'h03, "R11 count read-only");
    rd(5'h1C, 8'h00, "R11 reserved tester address");
    repeat (3) @(negedge clk);
    chk(rdata === 8'h00, "R12 rdata holds", rdata, 8'h00);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_NS * 100000);
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog R12 act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule